// File: doc/BRIEF.md
# Multiplexed Parallel Slave Port

This block is the device side of a 16-bit parallel host bus whose lines carry both address and data. The host selects the device with a chip select. It pulses an address-latch input to capture a word address from the low bits of the shared lines. It then sets a read/write level and raises one or both byte strobes to read or write a word in an internal synchronous memory.

The shared lines are modelled as a separate input vector, an output vector and one output-enable. The output is enabled only while the device is selected, the access is a read and a byte strobe has been seen. The address-latch input and both strobes pass through a multi-stage synchronizer into the core clock. A write is committed when the synchronized strobe falls, using the data and lanes gathered while it was high. If the host raises the address latch together with a strobe while selected, the block flags a protocol error and drops that access.

Top module: `muxport_slave`

## Requirements
- R1: While `cs` is high and the synchronized address-latch is high with no strobe seen, the block captures `bus_in[13:0]` as the word address. Memory is indexed by the low `MEM_AW` bits of that address, so addresses that differ only above those bits reach the same word.
- R2: With `rw` low (write) and only `bsel0` raised, bits 7:0 of `bus_in` are written and bits 15:8 of the word keep their value.
- R3: With `rw` low and only `bsel1` raised, bits 15:8 are written and bits 7:0 keep their value. With both strobes raised, the whole word is written.
- R4: A read (`rw` high) returns all 16 bits of the addressed word on `bus_out`, whether one strobe or both are raised.
- R5: `bus_oe` is low in every cycle in which `cs` is low or `rw` is low. It rises `SYNC_STAGES`+1 clock edges after a strobe is first sampled high, and it falls again after both strobes are low.
- R6: In the first cycle that `bus_oe` is high, `bus_out` is zero, which stands for the not-yet-valid period. From the next cycle on, it carries the read word. Whenever `bus_oe` is low, `bus_out` is zero.
- R7: The latched address is kept, so further strobes without a new latch pulse access the same word.
- R8: When `cs` is high and the synchronized address-latch and a synchronized strobe are high in the same cycle, `proto_err` is high for that cycle. The strobe's write is dropped, and no read output is enabled for the rest of that strobe.
- R9: While `cs` is low, strobes write nothing and address-latch pulses change no address.
- R10: After reset, `bus_oe` and `proto_err` are low and the latched address is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high (tie high if unused) |
| rw | input | 1 | High = read, low = write |
| al | input | 1 | Address-latch strobe |
| bsel0 | input | 1 | Low-byte strobe (bits 7:0) |
| bsel1 | input | 1 | High-byte strobe (bits 15:8) |
| bus_in | input | DATA_W | Shared lines as seen by the device |
| bus_out | output | DATA_W | Read data driven onto the shared lines |
| bus_oe | output | 1 | Drive enable for the shared lines |
| proto_err | output | 1 | Latch-with-strobe protocol violation |

## Verification
The bench builds the block with `MEM_AW` = 4, a 16-word memory, and keeps the two-stage synchronizer. The small memory lets latched addresses such as 0x3FF5 and 0x0005 land on the same word, which exercises the address truncation. Every byte-lane, error and deselect scenario stays inside a short run. The default 14-bit address and 16-bit data width are kept, so the full latch path across `bus_in[13:0]` is covered.

// File: rtl/muxport_pkg.sv
package muxport_pkg;
   localparam int BYTE_W = 8;

   typedef struct packed {
      logic al;
      logic b1;
      logic b0;
   } strobe_t;
endpackage

// File: rtl/muxport_sync.sv
module muxport_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/muxport_ram.sv
module muxport_ram #(
   parameter int AW    = 8,
   parameter int LANES = 2
) (
   input  logic                 clk,
   input  logic                 we,
   input  logic [LANES-1:0]     be,
   input  logic [AW-1:0]        addr,
   input  logic [LANES*8-1:0]   wdata,
   output logic [LANES*8-1:0]   rdata
);
   localparam int DEPTH = 1 << AW;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [7:0] cells [DEPTH];
      logic [7:0] rd_lane;

      always_ff @(posedge clk) begin
         if (we && be[i]) cells[addr] <= wdata[i*8 +: 8];
         rd_lane <= cells[addr];
      end

      assign rdata[i*8 +: 8] = rd_lane;
   end
endmodule

// File: rtl/muxport_slave.sv
module muxport_slave
   import muxport_pkg::*;
#(
   parameter int ADDR_W      = 14,
   parameter int DATA_W      = 16,
   parameter int MEM_AW      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              rw,
   input  logic              al,
   input  logic              bsel0,
   input  logic              bsel1,
   input  logic [DATA_W-1:0] bus_in,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_oe,
   output logic              proto_err
);
   localparam int LANES = DATA_W / BYTE_W;

   if (LANES != 2 || (DATA_W % BYTE_W) != 0) begin : g_bad_width
      $error("muxport_slave: DATA_W must be 16 (two byte lanes)");
   end
   if (ADDR_W > DATA_W) begin : g_bad_addr
      $error("muxport_slave: ADDR_W must fit in DATA_W");
   end
   if (MEM_AW < 1 || MEM_AW > ADDR_W) begin : g_bad_mem
      $error("muxport_slave: MEM_AW must lie in 1..ADDR_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("muxport_slave: SYNC_STAGES must be at least 2");
   end

   strobe_t raw_s, syn_s;
   logic [2:0] syn_bits;

   assign raw_s = {al, bsel1, bsel0};

   muxport_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_s),
      .q     (syn_bits)
   );
   assign syn_s = syn_bits;

   logic act, err, spoil_n, fall;
   logic act_q, spoil_q, arm_q, oe_q, valid_q, err_q;
   logic [LANES-1:0]  be_q;
   logic [DATA_W-1:0] wd_q, rd_q;
   logic [ADDR_W-1:0] addr_q;

   assign act     = syn_s.b0 | syn_s.b1;
   assign err     = cs & syn_s.al & act;
   assign spoil_n = spoil_q | err;
   assign fall    = act_q & ~act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q   <= 1'b0;
         spoil_q <= 1'b0;
         arm_q   <= 1'b0;
         be_q    <= '0;
         wd_q    <= '0;
         addr_q  <= '0;
         oe_q    <= 1'b0;
         valid_q <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         act_q   <= act;
         err_q   <= err;
         spoil_q <= act & spoil_n;
         oe_q    <= act & ~spoil_n;
         valid_q <= oe_q & act & ~spoil_n;
         if (cs && syn_s.al && !act) addr_q <= bus_in[ADDR_W-1:0];
         if (fall || spoil_n) begin
            arm_q <= 1'b0;
            be_q  <= '0;
         end else if (act && cs && !rw) begin
            arm_q <= 1'b1;
            be_q  <= be_q | {syn_s.b1, syn_s.b0};
            wd_q  <= bus_in;
         end
      end
   end

   muxport_ram #(.AW(MEM_AW), .LANES(LANES)) u_ram (
      .clk   (clk),
      .we    (fall & arm_q),
      .be    (be_q),
      .addr  (addr_q[MEM_AW-1:0]),
      .wdata (wd_q),
      .rdata (rd_q)
   );

   assign bus_oe    = cs & rw & oe_q;
   assign bus_out   = (bus_oe && valid_q) ? rd_q : '0;
   assign proto_err = err_q;
endmodule

// File: rtl/muxport_chk.sv
module muxport_chk #(
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs,
   input logic              rw,
   input logic              al,
   input logic              bsel0,
   input logic              bsel1,
   input logic [DATA_W-1:0] bus_out,
   input logic              bus_oe,
   input logic              proto_err
);
   // R5
   hiz_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs || !rw) |-> !bus_oe);

   // R6
   out_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_oe |-> (bus_out == '0));

   // R8
   err_blocks_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |-> !bus_oe);

   if (SYNC_STAGES == 2) begin : g_two_stage
      // R5
      oe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
         bus_oe |-> $past(bsel0 | bsel1, 3));

      // R8
      err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
         proto_err |-> ($past(al, 3) && $past(bsel0 | bsel1, 3)));
   end
endmodule

bind muxport_slave muxport_chk #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs        (cs),
   .rw        (rw),
   .al        (al),
   .bsel0     (bsel0),
   .bsel1     (bsel1),
   .bus_out   (bus_out),
   .bus_oe    (bus_oe),
   .proto_err (proto_err)
);

// File: tb/muxport_slave_test.sv
module muxport_slave_test;
   localparam int MAW  = 4;
   localparam int SYNC = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs = 1'b0, rw = 1'b0, al = 1'b0, bsel0 = 1'b0, bsel1 = 1'b0;
   logic [15:0] bus_in = '0;
   logic [15:0] bus_out;
   logic bus_oe, proto_err;

   int n_checks = 0;
   int n_fails  = 0;
   string cur_req = "R10";
   int err_seen = 0;
   int oe_in_write = 0;

   always #5 clk = ~clk;

   muxport_slave #(.MEM_AW(MAW), .SYNC_STAGES(SYNC)) uut (
      .clk(clk), .rst_n(rst_n), .cs(cs), .rw(rw), .al(al),
      .bsel0(bsel0), .bsel1(bsel1), .bus_in(bus_in),
      .bus_out(bus_out), .bus_oe(bus_oe), .proto_err(proto_err)
   );

   task automatic check(input string req, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // behavioural reference model
   logic [2:0]  dq[$];
   logic [15:0] mm[int];
   int          m_addr;
   logic        m_arm, m_spoil, m_oe, m_valid, m_err, m_prev, m_rdk;
   logic [1:0]  m_be;
   logic [15:0] m_wd, m_rd;

   always @(posedge clk) begin
      if (!rst_n) begin
         dq = {};
         for (int i = 0; i < SYNC; i++) dq.push_back(3'b000);
         m_addr = 0; m_arm = 0; m_spoil = 0; m_oe = 0; m_valid = 0;
         m_err = 0; m_prev = 0; m_be = 0; m_wd = 0; m_rdk = 0; m_rd = 0;
      end else begin
         logic [2:0] s;
         logic a, e, sp;
         int idx;
         s = dq.pop_front();
         dq.push_back({al, bsel1, bsel0});
         a  = s[1] | s[0];
         e  = cs & s[2] & a;
         sp = m_spoil | e;
         idx = m_addr % (1 << MAW);
         m_rdk = mm.exists(idx);
         if (m_rdk) m_rd = mm[idx];
         if (m_prev && !a && m_arm) begin
            logic [15:0] w;
            w = mm.exists(idx) ? mm[idx] : 16'h0000;
            if (m_be[0]) w[7:0]  = m_wd[7:0];
            if (m_be[1]) w[15:8] = m_wd[15:8];
            mm[idx] = w;
         end
         m_valid = m_oe & a & !sp;
         m_oe    = a & !sp;
         if (cs && s[2] && !a) m_addr = int'(bus_in[13:0]);
         if ((m_prev && !a) || sp) begin
            m_arm = 0; m_be = 0;
         end else if (a && cs && !rw) begin
            m_arm = 1; m_be = m_be | s[1:0]; m_wd = bus_in;
         end
         m_spoil = a & sp;
         m_err = e;
         m_prev = a;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         logic exp_oe;
         exp_oe = cs & rw & m_oe;
         check(cur_req, "bus_oe vs model", {15'd0, bus_oe}, {15'd0, exp_oe});
         check("R8", "proto_err vs model", {15'd0, proto_err}, {15'd0, m_err});
         if (!exp_oe)
            check("R6", "bus_out idle", bus_out, 16'h0000);
         else if (m_valid && m_rdk)
            check(cur_req, "bus_out vs model", bus_out, m_rd);
         if (proto_err) err_seen++;
         if (bus_oe && !rw) oe_in_write++;
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic latch(input logic [15:0] a);
      @(negedge clk);
      bus_in = a; al = 1'b1;
      idle(2);
      al = 1'b0;
      idle(SYNC + 2);
   endtask

   task automatic wr(input logic [1:0] be, input logic [15:0] d);
      @(negedge clk);
      rw = 1'b0; bus_in = d; {bsel1, bsel0} = be;
      idle(3);
      {bsel1, bsel0} = 2'b00;
      idle(SYNC + 3);
   endtask

   task automatic rd(input logic [1:0] be, input string req, output logic [15:0] v);
      @(negedge clk);
      rw = 1'b1; {bsel1, bsel0} = be;
      for (int j = 1; j <= SYNC + 3; j++) begin
         @(negedge clk);
         if (j <= SYNC)
            check("R5", "bus_oe before sync", {15'd0, bus_oe}, 16'h0000);
         else if (j == SYNC + 1) begin
            check("R5", "bus_oe rise", {15'd0, bus_oe}, 16'h0001);
            check("R6", "bus_out first oe cycle", bus_out, 16'h0000);
         end
      end
      v = bus_out;
      {bsel1, bsel0} = 2'b00;
      idle(SYNC + 2);
      check("R5", "bus_oe after strobes low", {15'd0, bus_oe}, 16'h0000);
      rw = 1'b0;
   endtask

   initial begin
      logic [15:0] v;
      idle(4);
      cs = 1'b1; rw = 1'b1;
      @(negedge clk);
      check("R10", "bus_oe in reset", {15'd0, bus_oe}, 16'h0000);
      rst_n = 1'b1;
      idle(2);
      check("R10", "bus_oe after reset", {15'd0, bus_oe}, 16'h0000);
      check("R10", "proto_err after reset", {15'd0, proto_err}, 16'h0000);
      rw = 1'b0;

      cur_req = "R10";
      wr(2'b11, 16'hBEEF);
      rd(2'b11, "R10", v);
      check("R10", "reset address word", v, 16'hBEEF);

      cur_req = "R3";
      latch(16'h0005);
      wr(2'b11, 16'h1234);
      cur_req = "R2";
      wr(2'b01, 16'h77AB);
      rd(2'b11, "R2", v);
      check("R2", "low byte write", v, 16'h12AB);
      cur_req = "R3";
      wr(2'b10, 16'hCD55);
      rd(2'b11, "R3", v);
      check("R3", "high byte write", v, 16'hCDAB);

      cur_req = "R4";
      rd(2'b01, "R4", v);
      check("R4", "full word on bsel0 read", v, 16'hCDAB);
      rd(2'b10, "R4", v);
      check("R4", "full word on bsel1 read", v, 16'hCDAB);

      cur_req = "R1";
      latch(16'h0007);
      wr(2'b11, 16'h5678);
      latch(16'h3FF5);
      rd(2'b11, "R1", v);
      check("R1", "aliased address 0x3FF5", v, 16'hCDAB);

      cur_req = "R7";
      latch(16'h0007);
      wr(2'b01, 16'h0099);
      rd(2'b11, "R7", v);
      check("R7", "address kept over strobes", v, 16'h5699);
      check("R5", "bus_oe cycles during writes", 16'(oe_in_write), 16'h0000);

      cur_req = "R8";
      err_seen = 0;
      @(negedge clk);
      rw = 1'b0; bus_in = 16'hFFFF; al = 1'b1; {bsel1, bsel0} = 2'b11;
      idle(3);
      al = 1'b0; {bsel1, bsel0} = 2'b00;
      idle(SYNC + 3);
      check("R8", "protocol error flagged", {15'd0, err_seen != 0}, 16'h0001);
      latch(16'h0007);
      rd(2'b11, "R8", v);
      check("R8", "erroneous write dropped", v, 16'h5699);

      cur_req = "R9";
      cs = 1'b0;
      wr(2'b11, 16'h0000);
      latch(16'h0005);
      @(negedge clk);
      rw = 1'b1; bsel0 = 1'b1;
      idle(SYNC + 3);
      check("R9", "no drive while deselected", {15'd0, bus_oe}, 16'h0000);
      bsel0 = 1'b0; rw = 1'b0;
      idle(SYNC + 2);
      cs = 1'b1;
      rd(2'b11, "R9", v);
      check("R9", "write and latch ignored when deselected", v, 16'h5699);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      #2_000_000;
      n_fails++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule